// File: doc/BRIEF.md
# SPI Register Target with Direction Bit

This block is a 4-wire SPI target that lets an external host read and write a byte-wide register file. The host pulls the active-low select low, clocks in a command byte, and then moves any number of data bytes. The most significant bit of the command byte sets the direction. The lower bits give the starting register index, and the index then steps by one after every data byte. The chip logic reaches the same register file through a parallel side port, with a synchronous write and a combinational read.

The SPI pins are asynchronous to the block clock `clk`. Each pin passes through a `SYNC_STAGES`-deep synchronizer, and the block finds the serial clock edges by oversampling. The serial clock half period must therefore be at least `SYNC_STAGES + 3` cycles of `clk`. The MISO line is shown as a data bit `spi_miso` plus an enable `spi_miso_oe` for the pad driver. `spi_miso` reads 0 whenever the enable is low.

The control state machine has four states:
- `ST_IDLE`: select is high.
- `ST_ADDR`: the command byte is being shifted in.
- `ST_WRITE`: write data phase.
- `ST_READ`: read data phase.

Its transitions are:
- select seen low: `ST_IDLE` to `ST_ADDR`.
- command byte complete with direction bit 0: `ST_ADDR` to `ST_WRITE`.
- command byte complete with direction bit 1: `ST_ADDR` to `ST_READ`.
- select seen high: any state to `ST_IDLE`.

Top module: `spi_regfile_target`

## Requirements
- R1: After reset `spi_miso_oe` and `spi_miso` are 0, the state is `ST_IDLE`, and every register reads 0.
- R2: Raising `spi_csn` returns the block to `ST_IDLE` and clears the bit count. The next low period always begins with a new command byte, whatever point the previous transaction had reached.
- R3: MOSI is sampled on rising SCK edges, most significant bit first, so a written byte 0x01 is stored as 0x01 and 0x80 as 0x80.
- R4: In the first byte after selection, bit 7 = 0 selects a write and bit 7 = 1 selects a read. Bits 6:0 are the starting register index. A read transaction leaves the registers unchanged.
- R5: In a write, each complete data byte is stored at the current index, and the index then increments, wrapping from 127 to 0. Registers that are not addressed keep their values.
- R6: In a read, MISO presents the register at the current index, most significant bit first. The first bit appears after the falling SCK edge that follows the command byte, and each further bit changes only after a falling edge. Each following byte comes from the next index, wrapping from 127 to 0.
- R7: `spi_miso_oe` is 1 only in `ST_READ`, which means select is low and the command byte is complete. It is 0 during the command byte, throughout a write, and while idle.
- R8: A data byte with fewer than 8 bits when select rises is discarded. Bytes completed earlier in the same transaction are kept.
- R9: A high `side_we` writes `side_wdata` to `side_addr` at the next clock edge. `side_rdata` always shows the register at `side_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when not driven |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| side_we | input | 1 | Side-port write strobe |
| side_addr | input | ADDR_W | Side-port register index |
| side_wdata | input | DATA_W | Side-port write data |
| side_rdata | output | DATA_W | Side-port read data, combinational |

## Verification
The bench builds the block with its defaults: `ADDR_W` = 7, `DATA_W` = 8 and `SYNC_STAGES` = 2. With 128 registers, a two-byte write starting at index 127 reaches the wrap to 0, and a three-byte read starting at 126 crosses it in the other direction. A serial half period of six clock cycles leaves the two-flop synchronizer and edge detector enough margin for every MISO bit to settle before the host's rising-edge sample. The bench also drops select mid-byte and then starts a fresh read, which exercises the discard and restart paths.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WRITE = 2'd2,
        ST_READ  = 2'd3
    } tgt_state_e;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic cs_active_o,
    output logic mosi_o
);
    localparam int NSIG   = 3;
    localparam int SCK_B  = 2;
    localparam int CSN_B  = 1;
    localparam int MOSI_B = 0;
    localparam logic [NSIG-1:0] IDLE_LVL = 3'b010;

    logic [NSIG-1:0]             pins;
    logic [STAGES-1:0][NSIG-1:0] chain;
    logic [NSIG-1:0]             synced;
    logic                        sck_prev;

    assign pins = {sck_i, csn_i, mosi_i};

    // Stage count picks the shift form of the synchronizer chain.
    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= IDLE_LVL;
            else        chain <= pins;
        end
    end else begin : g_multi
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{IDLE_LVL}};
            else        chain <= {chain[STAGES-2:0], pins};
        end
    end

    assign synced = chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= synced[SCK_B];
    end

    assign cs_active_o = ~synced[CSN_B];
    assign mosi_o      = synced[MOSI_B];
    assign sck_rise_o  = cs_active_o &  synced[SCK_B] & ~sck_prev;
    assign sck_fall_o  = cs_active_o & ~synced[SCK_B] &  sck_prev;

endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_we,
    input  logic [ADDR_W-1:0] spi_waddr,
    input  logic [DATA_W-1:0] spi_wdata,
    input  logic [ADDR_W-1:0] spi_raddr,
    output logic [DATA_W-1:0] spi_rdata,
    input  logic              side_we,
    input  logic [ADDR_W-1:0] side_addr,
    input  logic [DATA_W-1:0] side_wdata,
    output logic [DATA_W-1:0] side_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Side write first, serial write last: on a shared index the serial byte lands.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (side_we) mem[side_addr] <= side_wdata;
            if (spi_we)  mem[spi_waddr] <= spi_wdata;
        end
    end

    assign spi_rdata  = mem[spi_raddr];
    assign side_rdata = mem[side_addr];

endmodule

// File: rtl/spi_tgt_ctrl.sv
module spi_tgt_ctrl
    import spi_tgt_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              cs_active_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              miso_o,
    output logic              miso_oe_o,
    output tgt_state_e        state_o,
    output logic [$clog2(DATA_W)-1:0] bit_cnt_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tgt_state_e        state_q;
    tgt_state_e        state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-2:0] sh_in_q;
    logic [DATA_W-1:0] sh_out_q;
    logic [ADDR_W-1:0] idx_q;

    logic              byte_full;
    logic [DATA_W-1:0] word_in;
    logic              cmd_is_read;
    logic              in_cmd;

    assign byte_full   = sck_rise_i && (bit_cnt_q == LAST_BIT);
    assign word_in     = {sh_in_q, mosi_i};
    assign cmd_is_read = word_in[DATA_W-1];
    assign in_cmd      = (state_q == ST_IDLE) || (state_q == ST_ADDR);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (!cs_active_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_ADDR;
                ST_ADDR:  if (byte_full) state_d = cmd_is_read ? ST_READ : ST_WRITE;
                ST_WRITE: state_d = ST_WRITE;
                ST_READ:  state_d = ST_READ;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Bit counter and receive shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            sh_in_q   <= '0;
        end else if (!cs_active_i) begin
            bit_cnt_q <= '0;
        end else if (sck_rise_i) begin
            sh_in_q   <= word_in[DATA_W-2:0];
            bit_cnt_q <= byte_full ? '0 : bit_cnt_q + 1'b1;
        end
    end

    // Register index and transmit shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            sh_out_q <= '0;
        end else if (cs_active_i) begin
            if (in_cmd && byte_full) begin
                idx_q <= word_in[ADDR_W-1:0];
            end else if (state_q == ST_WRITE && byte_full) begin
                idx_q <= idx_q + 1'b1;
            end else if (state_q == ST_READ && sck_fall_i) begin
                if (bit_cnt_q == '0) begin
                    sh_out_q <= rd_data_i;
                    idx_q    <= idx_q + 1'b1;
                end else begin
                    sh_out_q <= {sh_out_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    // Outputs
    always_comb begin
        wr_en_o   = (state_q == ST_WRITE) && byte_full;
        wr_addr_o = idx_q;
        wr_data_o = word_in;
        rd_addr_o = idx_q;
        miso_o    = sh_out_q[DATA_W-1];
        miso_oe_o = (state_q == ST_READ);
        state_o   = state_q;
        bit_cnt_o = bit_cnt_q;
    end

endmodule

// File: rtl/spi_regfile_target.sv
module spi_regfile_target
    import spi_tgt_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              side_we,
    input  logic [ADDR_W-1:0] side_addr,
    input  logic [DATA_W-1:0] side_wdata,
    output logic [DATA_W-1:0] side_rdata
);
    localparam int CNT_W = $clog2(DATA_W);

    logic              sck_rise;
    logic              sck_fall;
    logic              cs_active;
    logic              mosi_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              miso_bit;
    logic              miso_oe;
    tgt_state_e        ctrl_state;
    logic [CNT_W-1:0]  bit_pos;

    spi_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (spi_sck),
        .csn_i      (spi_csn),
        .mosi_i     (spi_mosi),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .cs_active_o(cs_active),
        .mosi_o     (mosi_s)
    );

    spi_tgt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .cs_active_i(cs_active),
        .mosi_i     (mosi_s),
        .rd_data_i  (rd_data),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .rd_addr_o  (rd_addr),
        .miso_o     (miso_bit),
        .miso_oe_o  (miso_oe),
        .state_o    (ctrl_state),
        .bit_cnt_o  (bit_pos)
    );

    spi_tgt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_we    (wr_en),
        .spi_waddr (wr_addr),
        .spi_wdata (wr_data),
        .spi_raddr (rd_addr),
        .spi_rdata (rd_data),
        .side_we   (side_we),
        .side_addr (side_addr),
        .side_wdata(side_wdata),
        .side_rdata(side_rdata)
    );

    assign spi_miso_oe = miso_oe;
    assign spi_miso    = miso_oe ? miso_bit : 1'b0;

endmodule

// File: rtl/spi_tgt_checker.sv
module spi_tgt_checker
    import spi_tgt_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      spi_csn,
    input logic                      spi_miso,
    input logic                      spi_miso_oe,
    input logic                      sck_fall,
    input logic                      cs_active,
    input tgt_state_e                ctrl_state,
    input logic [$clog2(DATA_W)-1:0] bit_pos,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [ADDR_W-1:0]         rd_addr
);
    int csn_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  csn_hi_cnt <= 0;
        else if (!spi_csn)           csn_hi_cnt <= 0;
        else if (csn_hi_cnt < 15)    csn_hi_cnt <= csn_hi_cnt + 1;
    end

    // R2: select seen high puts the controller back to idle with a cleared count
    a_r2_cs_high_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (ctrl_state == ST_IDLE && bit_pos == '0));

    // R5: each committed byte moves the index on by one, wrapping at the top
    a_r5_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_addr == ADDR_W'($past(wr_addr) + 1'b1));

    // R6: while driven, MISO moves only after a falling serial clock edge
    a_r6_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && $past(spi_miso_oe) && !$stable(spi_miso)) |-> $past(sck_fall));

    // R7: once select has been high long enough to pass the synchronizer, MISO is released
    a_r7_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_hi_cnt >= SYNC_STAGES + 1) |-> !spi_miso_oe);

    // R8: a commit only ever closes a whole byte
    a_r8_whole_byte: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bit_pos == '0);

endmodule

bind spi_regfile_target spi_tgt_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_csn    (spi_csn),
    .spi_miso   (spi_miso),
    .spi_miso_oe(spi_miso_oe),
    .sck_fall   (sck_fall),
    .cs_active  (cs_active),
    .ctrl_state (ctrl_state),
    .bit_pos    (bit_pos),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr)
);

// File: tb/spi_regfile_target_bench.sv
`timescale 1ns/1ps
module spi_regfile_target_bench;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 128;
    localparam int HP     = 6;
    localparam int PH_IDLE = 0, PH_ADDR = 1, PH_WR = 2, PH_RD = 3, PH_GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic side_we = 1'b0;
    logic [ADDR_W-1:0] side_addr = '0;
    logic [DATA_W-1:0] side_wdata = '0;
    logic [DATA_W-1:0] side_rdata;

    int checks = 0;
    int errors = 0;
    int phase = PH_IDLE;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    spi_regfile_target u_spi_regfile_target (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .side_we(side_we),
        .side_addr(side_addr), .side_wdata(side_wdata), .side_rdata(side_rdata)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the behavioural model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (phase == PH_IDLE) begin
                chk("R7", "idle miso enable", spi_miso_oe, 0);
                chk("R9", "idle side read", side_rdata, model[side_addr]);
            end else if (phase == PH_ADDR || phase == PH_WR) begin
                chk("R7", "miso enable in command/write", spi_miso_oe, 0);
            end
        end
    end

    task automatic shift_bits(input logic [7:0] b, input int n, input int ph_last, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i];
            repeat (HP) @(negedge clk);
            r[i] = spi_miso;
            if (i == 7 && phase == PH_RD) chk("R7", "miso enable during read data", spi_miso_oe, 1);
            sck = 1'b1;
            if (i == 0 && ph_last >= 0) phase = ph_last;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic begin_tx();
        @(negedge clk);
        csn = 1'b0;
        phase = PH_ADDR;
        repeat (HP) @(negedge clk);
    endtask

    task automatic end_tx();
        repeat (HP) @(negedge clk);
        csn = 1'b1;
        phase = PH_GAP;
        repeat (2 * HP) @(negedge clk);
        phase = PH_IDLE;
    endtask

    task automatic spi_write(input int idx, input logic [7:0] data[$]);
        logic [7:0] r;
        int a = idx;
        begin_tx();
        shift_bits({1'b0, 7'(idx)}, 8, PH_WR, r);
        foreach (data[k]) begin
            shift_bits(data[k], 8, -1, r);
            model[a] = data[k];
            a = (a + 1) % DEPTH;
        end
        end_tx();
    endtask

    task automatic spi_read(input int idx, input int n, input string req);
        logic [7:0] r;
        int a = idx;
        begin_tx();
        shift_bits({1'b1, 7'(idx)}, 8, PH_RD, r);
        for (int k = 0; k < n; k++) begin
            shift_bits(8'h5A, 8, -1, r);
            chk(req, $sformatf("read byte idx %0d", a), r, model[a]);
            a = (a + 1) % DEPTH;
        end
        end_tx();
    endtask

    task automatic side_write(input int a, input logic [7:0] d);
        @(negedge clk);
        side_we = 1'b1;
        side_addr = 7'(a);
        side_wdata = d;
        model[a] = d;
        @(negedge clk);
        side_we = 1'b0;
    endtask

    task automatic check_reg(input int a, input string req);
        @(negedge clk);
        side_addr = 7'(a);
        @(posedge clk);
        #2;
        chk(req, $sformatf("register %0d", a), side_rdata, model[a]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired before the sequence finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "miso enable after reset", spi_miso_oe, 0);
        chk("R1", "miso after reset", spi_miso, 0);
        check_reg(0, "R1");
        check_reg(64, "R1");
        check_reg(127, "R1");

        // R9: side port writes and reads
        side_write(10, 8'h11);
        side_write(11, 8'h22);
        side_write(12, 8'h80);
        side_write(13, 8'h01);
        side_write(31, 8'h42);
        check_reg(10, "R9");
        check_reg(13, "R9");
        check_reg(31, "R9");

        // R6: multi-byte read with increment
        spi_read(10, 4, "R6");
        // R4: a read leaves the registers alone
        check_reg(10, "R4");
        check_reg(11, "R4");

        // R5 / R3: write burst with increment and bit order
        spi_write(20, '{8'hA5, 8'h3C, 8'h01, 8'h80});
        check_reg(20, "R5");
        check_reg(21, "R5");
        check_reg(22, "R3");
        check_reg(23, "R3");
        check_reg(24, "R5");

        // R4: direction bit on the same index
        spi_write(5, '{8'h96});
        spi_read(5, 1, "R4");

        // R5 / R6: wrap from 127 to 0
        spi_write(127, '{8'hC3, 8'h7E});
        check_reg(127, "R5");
        check_reg(0, "R5");
        check_reg(1, "R5");
        spi_read(126, 3, "R6");

        // R8: partial byte at deselect is dropped
        begin_tx();
        shift_bits({1'b0, 7'd30}, 8, PH_WR, r);
        shift_bits(8'h77, 8, -1, r);
        model[30] = 8'h77;
        shift_bits(8'hFF, 5, -1, r);
        end_tx();
        check_reg(30, "R8");
        check_reg(31, "R8");

        // R2: next transaction starts with a fresh command byte
        spi_read(30, 2, "R2");
        spi_write(40, '{8'hE1});
        check_reg(40, "R2");
        check_reg(41, "R2");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule